// File: doc/BRIEF.md
# Parallel Printer Byte Feeder

This block moves characters from a fast on-chip producer to a slow parallel printer. The producer offers one byte at a time on a valid/ready pair. For each byte the block waits until the printer reports that it is idle. It then drives the byte onto an 8-bit data port and keeps it there for a set setup time. Next it pulses an active-low strobe for a fixed width and keeps the data steady for a hold time.

After the strobe the block waits for the printer's busy line to go high and then low again before it takes another byte. This paces the producer to the printer's speed without any software polling loop. The busy line is asynchronous to the block clock, so it passes through a two-stage synchronizer before any decision uses it. If busy never rises after a strobe, a timeout returns the block to idle and raises a one-cycle flag.

All timing windows are counted in clock cycles and set by parameters: setup, strobe width, hold and rise timeout.

Top module: `lp_byte_feeder`

## Requirements
- R1: While reset is held and right after it, the strobe is high (inactive), the data port is 0, the timeout flag is 0, and `in_ready` is 1 as long as busy is low.
- R2: `in_ready` is 1 only when the block is idle and the synchronized busy is low. If busy is held high while idle, no byte is taken and no strobe is issued. `in_ready` drops in the cycle after a byte is accepted.
- R3: An accepted byte appears on `pd_data` in the cycle after acceptance and stays unchanged until the next byte is accepted.
- R4: `pd_data` holds the new byte for at least `SETUP_CYC` cycles before the strobe falls.
- R5: The strobe is low for exactly `STROBE_CYC` consecutive cycles per byte.
- R6: After a strobe, no new byte is accepted until busy has been seen high and then low. `in_ready` can return no earlier than the third clock edge after busy goes low.
- R7: A busy pulse that starts and ends during the strobe or hold window counts as the rise. Such a pulse causes no timeout and allows the next byte.
- R8: If busy is never seen high, `busy_timeout` pulses for exactly one cycle, `HOLD_CYC + RISE_TMO` cycles after the strobe rises, and the block returns to idle.
- R9: Exactly one strobe pulse is issued per accepted byte, carrying the bytes in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | DATA_W | Byte offered by the producer |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| pd_data | output | DATA_W | Printer data lines |
| pd_strobe_n | output | 1 | Active-low data strobe to the printer |
| pd_busy | input | 1 | Printer busy, asynchronous, high while printing |
| busy_timeout | output | 1 | One-cycle flag: busy never rose after a strobe |

## Verification
The bench models a printer in three moods.
- A well-behaved printer raises busy after the strobe ends. A design that released `in_ready` on the busy rise alone, or skipped the synchronizer delay, would be flagged for taking a byte while the transfer is still in flight.
- A quick printer pulses busy entirely inside the strobe and hold window. A design that only looks for busy after the hold phase would miss the pulse and raise a false timeout.
- A silent printer never raises busy. This checks that the timeout fires once, at the exact cycle the windows add up to. A wrong count or a stuck flag shows up as a timing mismatch or an extra pulse.

Two further checks cover idle behaviour and repeated bytes. Holding busy high while idle must block acceptance and any strobe. Back-to-back identical bytes still need one strobe each.

// File: rtl/lpf_pkg.sv
// Shared types and helpers for the parallel printer byte feeder.
package lpf_pkg;

    // Sequencer phases of one byte transfer.
    typedef enum logic [2:0] {
        LPF_IDLE      = 3'd0,
        LPF_SETUP     = 3'd1,
        LPF_STROBE    = 3'd2,
        LPF_HOLD      = 3'd3,
        LPF_WAIT_RISE = 3'd4,
        LPF_WAIT_FALL = 3'd5
    } lpf_state_e;

    // Largest of four cycle counts, used to size the shared phase counter.
    function automatic int lpf_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lpf_busy_sync.sv
// Multi-stage synchronizer for the printer busy line.
// Assumes: the input is asynchronous and level-based. STAGES >= 2.
// The output lags the input by STAGES clock edges.
module lpf_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lpf_phase_timer.sv
// Cycle counter shared by all timed phases of the sequencer.
// Assumes: clear is raised in the first cycle of each phase, and limit >= 1.
// done is high in the last cycle of a phase of 'limit' cycles.
module lpf_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] count_q;

    // Restart on phase entry, otherwise count up.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count_q <= '0;
        else                 count_q <= count_q + 1'b1;
    end

    assign done = (count_q == limit - 1'b1);

endmodule

// File: rtl/lpf_sequencer.sv
// Transfer sequencer: accepts a byte, times setup, strobe and hold, then waits
// for the busy rise and fall, with a timeout on the rise.
// Assumes: busy_s is already synchronized. The timer restarts on every state change.
module lpf_sequencer
    import lpf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 5,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 2,
    parameter int RISE_TMO   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              busy_s,
    input  logic              tmr_done,
    output logic              tmr_clear,
    output logic [CNT_W-1:0]  tmr_limit,
    output logic              in_ready,
    output logic [DATA_W-1:0] pd_data,
    output logic              pd_strobe_n,
    output logic              busy_timeout
);

    lpf_state_e        st_q, st_d;
    logic [DATA_W-1:0] data_q;
    logic              strobe_n_q;
    logic              tmo_q, tmo_d;
    logic              rise_seen_q;
    logic              accept;

    assign in_ready  = (st_q == LPF_IDLE) && !busy_s;
    assign accept    = in_ready && in_valid;
    assign tmr_clear = (st_d != st_q);

    // Pick the length of the current timed phase.
    always_comb begin
        case (st_q)
            LPF_SETUP:     tmr_limit = CNT_W'(SETUP_CYC);
            LPF_STROBE:    tmr_limit = CNT_W'(STROBE_CYC);
            LPF_HOLD:      tmr_limit = CNT_W'(HOLD_CYC);
            LPF_WAIT_RISE: tmr_limit = CNT_W'(RISE_TMO);
            default:       tmr_limit = CNT_W'(1);
        endcase
    end

    // Next-state decision for the transfer phases.
    always_comb begin
        st_d  = st_q;
        tmo_d = 1'b0;
        case (st_q)
            LPF_IDLE:      if (accept)   st_d = LPF_SETUP;
            LPF_SETUP:     if (tmr_done) st_d = LPF_STROBE;
            LPF_STROBE:    if (tmr_done) st_d = LPF_HOLD;
            LPF_HOLD:      if (tmr_done) st_d = LPF_WAIT_RISE;
            LPF_WAIT_RISE: begin
                if (rise_seen_q || busy_s) begin
                    st_d = LPF_WAIT_FALL;
                end else if (tmr_done) begin
                    st_d  = LPF_IDLE;
                    tmo_d = 1'b1;
                end
            end
            LPF_WAIT_FALL: if (!busy_s)  st_d = LPF_IDLE;
            default:       st_d = LPF_IDLE;
        endcase
    end

    // State, strobe and timeout flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= LPF_IDLE;
            strobe_n_q <= 1'b1;
            tmo_q      <= 1'b0;
        end else begin
            st_q       <= st_d;
            strobe_n_q <= (st_d != LPF_STROBE);
            tmo_q      <= tmo_d;
        end
    end

    // Data latch: loads only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= in_data;
    end

    // Remember a busy rise seen during strobe, hold or rise wait.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            rise_seen_q <= 1'b0;
        end else if (busy_s && (st_q == LPF_STROBE || st_q == LPF_HOLD ||
                                st_q == LPF_WAIT_RISE)) begin
            rise_seen_q <= 1'b1;
        end
    end

    assign pd_data      = data_q;
    assign pd_strobe_n  = strobe_n_q;
    assign busy_timeout = tmo_q;

    // R2
    ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> pd_strobe_n);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(pd_data));

    // R5
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_strobe_n |-> (st_q == LPF_STROBE));

    // R6
    fall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LPF_WAIT_FALL && busy_s) |=> (st_q == LPF_WAIT_FALL));

    // R8
    timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_timeout |=> !busy_timeout);

    // R8
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_timeout |-> (st_q == LPF_IDLE));

endmodule

// File: rtl/lp_byte_feeder.sv
// Parallel printer byte feeder: paces a valid/ready byte producer to a slow
// printer through a strobe and busy handshake.
// Assumes: pd_busy is asynchronous. All cycle parameters are >= 1.
module lp_byte_feeder #(
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 2,
    parameter int STROBE_CYC  = 3,
    parameter int HOLD_CYC    = 2,
    parameter int RISE_TMO    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [DATA_W-1:0] pd_data,
    output logic              pd_strobe_n,
    input  logic              pd_busy,
    output logic              busy_timeout
);

    localparam int MAX_CNT = lpf_pkg::lpf_max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, RISE_TMO);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic             busy_s;
    logic             tmr_clear;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;

    lpf_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pd_busy),
        .sync_out (busy_s)
    );

    lpf_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    lpf_sequencer #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RISE_TMO   (RISE_TMO)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .busy_s       (busy_s),
        .tmr_done     (tmr_done),
        .tmr_clear    (tmr_clear),
        .tmr_limit    (tmr_limit),
        .in_ready     (in_ready),
        .pd_data      (pd_data),
        .pd_strobe_n  (pd_strobe_n),
        .busy_timeout (busy_timeout)
    );

endmodule

// File: tb/tb_lp_byte_feeder.sv
module tb_lp_byte_feeder;

    localparam int S_C = 2;
    localparam int T_C = 3;
    localparam int H_C = 2;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [7:0] pd_data;
    logic       pd_strobe_n;
    logic       pd_busy;
    logic       busy_timeout;

    logic model_busy = 1'b0;
    logic hold_busy  = 1'b0;
    assign pd_busy = model_busy | hold_busy;

    always #10 clk = ~clk;

    lp_byte_feeder #(
        .DATA_W(8), .SETUP_CYC(S_C), .STROBE_CYC(T_C), .HOLD_CYC(H_C),
        .RISE_TMO(TMO), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pd_data(pd_data), .pd_strobe_n(pd_strobe_n),
        .pd_busy(pd_busy), .busy_timeout(busy_timeout)
    );

    int checks = 0;
    int fails = 0;
    int sent = 0;
    int strobes = 0;
    int tmo_cnt = 0;
    int mode = 0;          // 0 normal printer, 1 silent, 2 quick pulse
    logic [7:0] exp_q[$];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor and printer model, all at the falling edge.
    logic       prev_strb = 1'b1;
    logic [7:0] prev_data = 8'h00;
    int stab = 0;
    int lowcyc = 0;
    int since_rise = 0;
    bit inflight = 0;
    bit seen_hi = 0;
    int lowcnt = 0;
    int pdelay = 0;
    int bcnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pd_data != prev_data) stab = 1; else stab++;
            if (prev_strb && !pd_strobe_n) begin
                strobes++;
                lowcyc = 1;
                inflight = 1; seen_hi = 0; lowcnt = 0;
                // R4 setup window
                chk(stab >= S_C + 1, "R4 setup", stab - 1, S_C);
                // R9 order and data of each strobe
                if (exp_q.size() == 0) chk(0, "R9 unexpected strobe", pd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(pd_data == e, "R9 strobe data", pd_data, e);
                end
                if (mode == 2) begin model_busy = 1'b1; bcnt = 2; end
            end else if (!pd_strobe_n) begin
                lowcyc++;
            end
            if (!prev_strb && pd_strobe_n) begin
                // R5 strobe width
                chk(lowcyc == T_C, "R5 width", lowcyc, T_C);
                since_rise = 0;
                if (mode == 0) pdelay = 2;
            end else begin
                since_rise++;
            end
            if (busy_timeout) begin
                tmo_cnt++;
                // R8 timeout position
                chk(since_rise == H_C + TMO, "R8 timeout timing", since_rise, H_C + TMO);
                inflight = 0;
            end
            if (model_busy) begin seen_hi = 1; lowcnt = 0; end
            else lowcnt++;
            if (inflight && seen_hi && lowcnt >= 3) inflight = 0;
            // R6 no acceptance while the transfer is open
            if (inflight && in_ready) chk(0, "R6 early ready", in_ready, 0);
            prev_strb = pd_strobe_n;
            prev_data = pd_data;
            // printer model update
            if (pdelay > 0) begin
                pdelay--;
                if (pdelay == 0) begin model_busy = 1'b1; bcnt = 6; end
            end else if (bcnt > 0) begin
                bcnt--;
                if (bcnt == 0) model_busy = 1'b0;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            summary();
        end
    end

    task automatic send_byte(input logic [7:0] b);
        exp_q.push_back(b);
        sent++;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // R2 ready drops after acceptance
        chk(in_ready == 1'b0, "R2 ready after accept", in_ready, 0);
        // R3 byte on the data port
        chk(pd_data == b, "R3 data driven", pd_data, b);
    endtask

    task automatic drain();
        @(negedge clk);
        while (inflight || !in_ready || exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 outputs under reset
        chk(pd_strobe_n == 1'b1, "R1 strobe idle", pd_strobe_n, 1);
        chk(pd_data == 8'h00, "R1 data zero", pd_data, 0);
        chk(busy_timeout == 1'b0, "R1 no timeout", busy_timeout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

        mode = 0;
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF);
        send_byte(8'h00); send_byte(8'h5A); send_byte(8'h5A);
        drain();
        // R3 data held after last transfer
        chk(pd_data == 8'h5A, "R3 data held", pd_data, 8'h5A);

        // R2 busy high while idle blocks acceptance and strobe
        hold_busy = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready with busy", in_ready, 0);
        begin
            int s0;
            bit bad;
            s0 = strobes;
            bad = 0;
            exp_q.push_back(8'h81);
            sent++;
            in_valid = 1'b1;
            in_data = 8'h81;
            repeat (20) begin
                @(negedge clk);
                if (in_ready) bad = 1;
            end
            chk(!bad && strobes == s0, "R2 held off by busy", strobes - s0, 0);
            chk(pd_data == 8'h5A, "R2 data untouched", pd_data, 8'h5A);
            hold_busy = 1'b0;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
        drain();

        // R7 quick busy pulse inside strobe window
        mode = 2;
        send_byte(8'h7E); send_byte(8'hC3);
        drain();
        chk(tmo_cnt == 0, "R7 no timeout on quick pulse", tmo_cnt, 0);

        // R8 silent printer
        mode = 1;
        send_byte(8'h99);
        drain();
        chk(tmo_cnt == 1, "R8 one timeout", tmo_cnt, 1);

        mode = 0;
        send_byte(8'h42);
        drain();
        repeat (5) @(negedge clk);
        chk(strobes == sent, "R9 strobe count", strobes, sent);
        chk(exp_q.size() == 0, "R9 queue empty", exp_q.size(), 0);
        chk(tmo_cnt == 1, "R8 no extra timeout", tmo_cnt, 1);
        chk(pd_data == 8'h42, "R3 final data", pd_data, 8'h42);
        summary();
    end

endmodule